// File: doc/BRIEF.md
# Bit-Serial Adder with Halt Counter

This block adds two unsigned N-bit operands one bit position per clock. It uses a single full-adder cell and one carry flip-flop, not a parallel adder. A start pulse on an idle block loads both operands into their own shift registers and clears the carry. On each following clock both registers shift right. Their low bits enter the full-adder cell together with the stored carry. The resulting sum bit enters the top of the augend register, so the sum builds up in place and replaces the augend.

A down counter is preset to N at load and counts one step per shift. When it reaches zero the block stops shifting, drops busy and pulses done for one clock. At that point the sum output shows the complete N-bit result and carry_out shows the final carry. Both values are held until the next accepted start.

Top module: `bit_serial_adder`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, sum is 0, carry_out is 0, busy is 0 and done is 0.
- R2: A start sampled while busy is low loads both operands. From the next cycle busy is 1, sum equals the loaded augend and carry_out is 0, so bit 0 is added with carry-in 0.
- R3: N cycles after the load, sum equals (augend + addend) mod 2^N.
- R4: When the operation ends, carry_out equals bit N of augend + addend. It holds that value until the next accepted start.
- R5: busy stays high for exactly N cycles after the load cycle and then falls.
- R6: done is high for exactly one cycle, the cycle in which busy first reads 0 after an operation.
- R7: A start sampled while busy is high has no effect. The running operation still finishes with the original operands' result at the original time.
- R8: While idle and without start, sum and carry_out do not change.
- R9: After k shifts (1 ≤ k ≤ N), sum bits [N-1:N-k] hold the low k bits of the result, and bits [N-k-1:0] hold the augend shifted right by k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; accepted only while idle |
| augend | input | N | First operand, loaded in parallel |
| addend | input | N | Second operand, loaded in parallel |
| sum | output | N | Augend/sum register contents |
| carry_out | output | 1 | Carry flip-flop; final carry once done |
| busy | output | 1 | High while shifts remain |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions check four things: the load effect of an accepted start, a counter step of exactly one per shift while busy (so a start during busy cannot reload), the one-cycle width of done, and that sum and carry_out stay stable while idle. Only the bench's scenarios can show the arithmetic. It sweeps every operand pair of the 4-bit default, checks the partially built sum after each shift, checks the final sum and carry, and checks that a start pulsed mid-operation leaves the result unchanged.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic a, input logic b, input logic cin);
        fa_out_t r;
        r.sum   = a ^ b ^ cin;
        r.carry = (a & b) | (a & cin) | (b & cin);
        return r;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bsa_shift_reg.sv
module bsa_shift_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    input  logic         ser_in,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= din;
        else if (shift) q <= {ser_in, q[W-1:1]};
    end

    p_shift_r9: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (q[W-1] == $past(ser_in)) && (q[W-2:0] == $past(q[W-1:1])));

endmodule

// File: rtl/bsa_carry_cell.sv
module bsa_carry_cell
    import bsa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic enable,
    input  logic a,
    input  logic b,
    output logic sum_bit,
    output logic carry_q
);

    fa_out_t fa;

    always_comb fa = full_add(a, b, carry_q);
    assign sum_bit = fa.sum;

    always_ff @(posedge clk) begin
        if (rst)         carry_q <= 1'b0;
        else if (clear)  carry_q <= 1'b0;
        else if (enable) carry_q <= fa.carry;
    end

    p_carry_clear_r2: assert property (@(posedge clk) disable iff (rst)
        clear |=> !carry_q);

    p_carry_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!clear && !enable) |=> $stable(carry_q));

endmodule

// File: rtl/bsa_halt_counter.sv
module bsa_halt_counter #(
    parameter int N  = 4,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    output logic [CW-1:0] cnt,
    output logic          running,
    output logic          last
);

    localparam logic [CW-1:0] PRESET = CW'(N);

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (load)             cnt <= PRESET;
        else if (step && running)  cnt <= cnt - 1'b1;
    end

    assign running = (cnt != '0);
    assign last    = (cnt == CW'(1));

    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (running && !load) |=> cnt == CW'($past(cnt) - 1'b1));

    p_count_preset_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == PRESET);

endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder
    import bsa_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] augend,
    input  logic [N-1:0] addend,
    output logic [N-1:0] sum,
    output logic         carry_out,
    output logic         busy,
    output logic         done
);

    localparam int CW = cnt_width(N);

    logic          go;
    logic          shifting;
    logic          running;
    logic          last;
    logic [CW-1:0] cnt;
    logic [N-1:0]  acc_q;
    logic [N-1:0]  add_q;
    logic          sum_bit;
    logic          carry_q;
    logic          done_q;

    assign go       = start && !running;
    assign shifting = running;

    bsa_halt_counter #(.N(N), .CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .load(go), .step(shifting),
        .cnt(cnt), .running(running), .last(last)
    );

    bsa_shift_reg #(.W(N)) u_acc (
        .clk(clk), .rst(rst), .load(go), .shift(shifting),
        .din(augend), .ser_in(sum_bit), .q(acc_q)
    );

    bsa_shift_reg #(.W(N)) u_add (
        .clk(clk), .rst(rst), .load(go), .shift(shifting),
        .din(addend), .ser_in(1'b0), .q(add_q)
    );

    bsa_carry_cell u_fa (
        .clk(clk), .rst(rst), .clear(go), .enable(shifting),
        .a(acc_q[0]), .b(add_q[0]), .sum_bit(sum_bit), .carry_q(carry_q)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= shifting && last;
    end

    assign sum       = acc_q;
    assign carry_out = carry_q;
    assign busy      = running;
    assign done      = done_q;

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy && !carry_out && (sum == $past(augend)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_edge_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy));

    p_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(sum) && $stable(carry_out));

    p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> sum[N-2:0] == $past(sum[N-1:1]));

endmodule

// File: tb/bit_serial_adder_test.sv
module bit_serial_adder_test;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [N-1:0] augend = '0;
    logic [N-1:0] addend = '0;
    logic [N-1:0] sum;
    logic         carry_out;
    logic         busy;
    logic         done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bit_serial_adder #(.N(N)) uut (
        .clk(clk), .rst(rst), .start(start), .augend(augend), .addend(addend),
        .sum(sum), .carry_out(carry_out), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Full operation with per-cycle checks; optional stray start at shift step `stray_at`.
    task automatic run_op(input int a, input int b, input int stray_at);
        int res;
        int exp_sum;
        int mask;
        @(negedge clk);
        augend = N'(a);
        addend = N'(b);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        res = a + b;
        chk(busy === 1'b1, "R2 busy after load", int'(busy), 1);
        chk(sum === N'(a), "R2 sum loaded", int'(sum), a);
        chk(carry_out === 1'b0, "R2 carry cleared", int'(carry_out), 0);
        for (int k = 1; k <= N; k++) begin
            if (k == stray_at) begin
                augend = N'(~a);
                addend = N'(~b);
                start  = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            mask = (1 << k) - 1;
            exp_sum = ((res & mask) << (N - k)) | (a >> k);
            chk(sum === N'(exp_sum), "R9 partial sum", int'(sum), exp_sum);
            chk(busy === (k < N), "R5 busy window", int'(busy), int'(k < N));
            chk(done === (k == N), "R6 done timing", int'(done), int'(k == N));
        end
        chk(sum === N'(res), "R3 final sum", int'(sum), res & ((1 << N) - 1));
        chk(carry_out === res[N], "R4 final carry", int'(carry_out), (res >> N) & 1);
        if (stray_at != 0)
            chk(sum === N'(res), "R7 stray start ignored", int'(sum), res & ((1 << N) - 1));
        @(negedge clk);
        chk(done === 1'b0, "R6 done single pulse", int'(done), 0);
        chk(sum === N'(res), "R8 sum held idle", int'(sum), res & ((1 << N) - 1));
        chk(carry_out === res[N], "R4 carry held", int'(carry_out), (res >> N) & 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sum === '0 && carry_out === 1'b0, "R1 reset data", int'(sum), 0);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", int'({busy, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && sum === '0, "R1 after reset", int'(sum), 0);

        for (int a = 0; a < (1 << N); a++)
            for (int b = 0; b < (1 << N); b++)
                run_op(a, b, 0);

        for (int s = 1; s <= N; s++)
            run_op(5, 9, s);
        run_op(15, 15, 2);

        repeat (3) @(negedge clk);
        chk(sum === N'(30) && busy === 1'b0, "R8 long idle", int'(sum), 30 & ((1 << N) - 1));
        finish_run();
    end

endmodule